// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Shared Interrupt

A sixteen-pin general-purpose I/O bank that sits on a simple memory-mapped register bus. Software sets each pin's drive direction, updates output levels through a masked write so that one access touches only the selected pins without a read-modify-write, reads back the synchronised pin levels, and chooses which of the upper eight pins may contribute to a single shared interrupt request. The lower eight pins each raise their own interrupt line whenever their synchronised level is high.

A control register holds the whole bank in a soft reset and gates its capture clock. Bringing the bank up takes a write of 3 (clock on, reset held) followed by a write of 1 (clock on, reset released). A write of 2 parks it in a low-power reset. While the capture clock is off, the sampled pin levels freeze and every interrupt output is held low.

Top module: `gpio16_shirq`

## Requirements
- R1: After rst_ni the control register reads 2 (bit 1 = block reset set, bit 0 = clock enable clear), the other registers read zero, and pin_o, pin_oe_o, irq_lo_o and irq_shared_o are all low.
- R2: The direction register at byte offset 0x00 is read/write in bits 15:0, and a 1 in bit i drives pin_oe_o[i] high.
- R3: A write to offset 0x08 updates output bit i to wdata bit i only where wdata bit 16+i is 1, leaving all other bits unchanged; reads of 0x08 return the output levels in bits 15:0 with bits 31:16 zero, and pin_o follows that register.
- R4: Offset 0x0C returns the pin levels through a two-stage synchroniser, so a pin change is readable after two clock edges.
- R5: The interrupt-enable register at offset 0x10 is read/write in bits 15:0.
- R6: The control register at offset 0x14 is read/write in bits 1:0 (bit 0 clock enable, bit 1 block reset) and accepts writes in every state.
- R7: While the block-reset bit is 1, the direction, output and interrupt-enable registers and the sampled pin state are zero, and writes to those registers are ignored.
- R8: While the clock-enable bit is 0, the sampled pin state stays frozen at its last value and all interrupt outputs are low.
- R9: irq_lo_o[i] for pins 0 to 7 is high exactly when the sampled level of pin i is high and the clock is enabled, independent of the interrupt-enable bits.
- R10: irq_shared_o is high exactly when the clock is enabled and some pin among 8 to 15 has both a high sampled level and its enable bit set.
- R11: A read returns its data on rdata_o in the cycle after the request; reads of unmapped offsets such as 0x04 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and bank clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Output levels to the pads |
| pin_oe_o | output | 16 | Per-pin output enable |
| irq_lo_o | output | 8 | Individual interrupt lines of pins 0 to 7 |
| irq_shared_o | output | 1 | Shared interrupt of pins 8 to 15 |

## Verification
The hardest state to reach is a frozen capture: the pins must change while the clock-enable bit is low, and the stale value can only be seen through a pin-state read, since every interrupt output is forced low at that time. The stimulus raises a shared interrupt first, turns the clock off, drops the pins, and reads the pin-state register to find the old levels before it restores the clock and watches the new level arrive. The soft reset is also entered from a fully programmed state, so the clearing of each register is visible in read-back.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DIR = 5'h00,
    OFF_OUT = 5'h08,
    OFF_PIN = 5'h0C,
    OFF_IEN = 5'h10,
    OFF_CTL = 5'h14
  } reg_off_e;

  typedef struct packed {
    logic blk_rst;
    logic clk_en;
  } ctl_t;

  localparam ctl_t CTL_RST_VAL = '{blk_rst: 1'b1, clk_en: 1'b0};
endpackage

// File: rtl/gpio16_regs.sv
module gpio16_regs
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_PINS-1:0] pin_state_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] ien_o,
  output ctl_t              ctl_o
);
  localparam int unsigned MASK_LSB = DATA_W / 2;

  logic              wr;
  logic              rd;
  logic [N_PINS-1:0] wr_mask;
  logic [N_PINS-1:0] wr_val;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic [N_PINS-1:0] dir_q, out_q, ien_q;
  ctl_t              ctl_q;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_mask = wdata_i[MASK_LSB +: N_PINS];
  assign wr_val  = wdata_i[N_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ctl_q <= CTL_RST_VAL;
    else if (wr && addr_i == OFF_CTL) ctl_q <= ctl_t'(wdata_i[1:0]);
  end

  // soft reset wins over bus writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (ctl_q.blk_rst) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (wr) begin
      if (addr_i == OFF_DIR) dir_q <= wr_val;
      if (addr_i == OFF_OUT) out_q <= (out_q & ~wr_mask) | (wr_val & wr_mask);
      if (addr_i == OFF_IEN) ien_q <= wr_val;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_DIR: rd_mux[N_PINS-1:0] = dir_q;
      OFF_OUT: rd_mux[N_PINS-1:0] = out_q;
      OFF_PIN: rd_mux[N_PINS-1:0] = pin_state_i;
      OFF_IEN: rd_mux[N_PINS-1:0] = ien_q;
      OFF_CTL: rd_mux[1:0]        = ctl_q;
      default: rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign ien_o   = ien_q;
  assign ctl_o   = ctl_q;
endmodule

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int unsigned N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_sync_o
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else if (clr_i) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else if (run_i) begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
      end
    end
    assign pin_sync_o[i] = s2_q;
  end
endmodule

// File: rtl/gpio16_irq.sv
module gpio16_irq #(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned N_SHARED = 8,
  localparam int unsigned N_LO    = N_PINS - N_SHARED
) (
  input  logic              clk_en_i,
  input  logic [N_PINS-1:0] pin_sync_i,
  input  logic [N_PINS-1:0] ien_i,
  output logic [N_LO-1:0]   irq_lo_o,
  output logic              irq_shared_o
);
  for (genvar i = 0; i < N_LO; i++) begin : g_lo
    assign irq_lo_o[i] = clk_en_i & pin_sync_i[i];
  end

  logic [N_SHARED-1:0] hit;
  assign hit          = pin_sync_i[N_PINS-1:N_LO] & ien_i[N_PINS-1:N_LO];
  assign irq_shared_o = clk_en_i & (|hit);
endmodule

// File: rtl/gpio16_shirq.sv
module gpio16_shirq
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned N_SHARED = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [N_PINS-1:0]          pin_i,
  output logic [N_PINS-1:0]          pin_o,
  output logic [N_PINS-1:0]          pin_oe_o,
  output logic [N_PINS-N_SHARED-1:0] irq_lo_o,
  output logic                       irq_shared_o
);
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] ien;
  ctl_t              ctl;
  logic              blk_rst;
  logic              blk_clk_en;

  assign blk_rst    = ctl.blk_rst;
  assign blk_clk_en = ctl.clk_en;

  gpio16_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pin_state_i(pin_sync),
    .rdata_o    (rdata_o),
    .dir_o      (pin_oe_o),
    .out_o      (pin_o),
    .ien_o      (ien),
    .ctl_o      (ctl)
  );

  gpio16_sync #(.N_PINS(N_PINS)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (blk_rst),
    .run_i     (blk_clk_en),
    .pin_i     (pin_i),
    .pin_sync_o(pin_sync)
  );

  gpio16_irq #(.N_PINS(N_PINS), .N_SHARED(N_SHARED)) u_irq (
    .clk_en_i    (blk_clk_en),
    .pin_sync_i  (pin_sync),
    .ien_i       (ien),
    .irq_lo_o    (irq_lo_o),
    .irq_shared_o(irq_shared_o)
  );
endmodule

// File: rtl/gpio16_shirq_chk.sv
module gpio16_shirq_chk
  import gpio16_pkg::*;
#(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned N_SHARED = 8,
  parameter int unsigned DATA_W   = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [N_PINS-1:0]          pin_o,
  input logic [N_PINS-1:0]          pin_oe_o,
  input logic [N_PINS-N_SHARED-1:0] irq_lo_o,
  input logic                       irq_shared_o,
  input logic                       blk_rst,
  input logic                       blk_clk_en
);
  localparam int unsigned MASK_LSB = DATA_W / 2;

  logic out_wr;
  logic ien_off_wr;
  assign out_wr     = req_i & we_i & (addr_i == OFF_OUT) & ~blk_rst;
  assign ien_off_wr = req_i & we_i & (addr_i == OFF_IEN) & ~blk_rst &
                      (wdata_i[N_PINS-1:N_PINS-N_SHARED] == '0);

  a_r7_soft_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_rst |=> (pin_oe_o == '0) && (pin_o == '0));

  a_r8_gated_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_clk_en |-> (irq_lo_o == '0) && !irq_shared_o);

  a_r3_unmasked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr |=> ((pin_o & ~$past(wdata_i[MASK_LSB +: N_PINS])) ==
                ($past(pin_o) & ~$past(wdata_i[MASK_LSB +: N_PINS]))));

  a_r3_masked_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr |=> ((pin_o & $past(wdata_i[MASK_LSB +: N_PINS])) ==
                ($past(wdata_i[N_PINS-1:0]) & $past(wdata_i[MASK_LSB +: N_PINS]))));

  a_r10_no_enable_no_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_off_wr |=> !irq_shared_o);
endmodule

bind gpio16_shirq gpio16_shirq_chk #(
  .N_PINS(N_PINS), .N_SHARED(N_SHARED), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/gpio16_shirq_tb.sv
module gpio16_shirq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic [7:0]  irq_lo;
  logic        irq_sh;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_due = 1'b0;

  always #10 clk = ~clk;

  gpio16_shirq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_lo_o(irq_lo), .irq_shared_o(irq_sh)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) mon_due <= req & ~we;
  always @(negedge clk) begin
    if (mon_due) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: unexpected read data actual %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", {16'h0, pin_oe}, 32'h0);
    check("R1 out", {16'h0, pin_out}, 32'h0);
    check("R1 irq", {23'h0, irq_sh, irq_lo}, 32'h0);
    bus_rd(5'h14, 32'h2, "R1 ctl reset value");
    bus_rd(5'h00, 32'h0, "R1 dir reset value");

    // writes ignored while held in reset
    bus_wr(5'h00, 32'h0000_FFFF);
    bus_wr(5'h08, 32'hFFFF_FFFF);
    bus_rd(5'h00, 32'h0, "R7 dir write ignored");
    bus_rd(5'h08, 32'h0, "R7 out write ignored");

    // bring-up
    bus_wr(5'h14, 32'h3);
    bus_wr(5'h14, 32'h1);
    bus_rd(5'h14, 32'h1, "R6 ctl readback");

    bus_wr(5'h00, 32'h0000_F0F0);
    bus_rd(5'h00, 32'h0000_F0F0, "R2 dir readback");
    check("R2 pin_oe", {16'h0, pin_oe}, 32'h0000_F0F0);

    bus_wr(5'h08, 32'h00FF_FFFF);
    check("R3 first masked write", {16'h0, pin_out}, 32'h0000_00FF);
    bus_wr(5'h08, 32'h0F0F_0000);
    check("R3 second masked write", {16'h0, pin_out}, 32'h0000_00F0);
    bus_rd(5'h08, 32'h0000_00F0, "R3 out readback");
    bus_wr(5'h08, 32'h0000_FFFF);
    bus_rd(5'h08, 32'h0000_00F0, "R3 zero mask no change");

    pin_in = 16'h0005;
    settle();
    bus_rd(5'h0C, 32'h0000_0005, "R4 pin state");
    check("R9 lower irqs", {24'h0, irq_lo}, 32'h05);
    check("R10 shared idle", {31'h0, irq_sh}, 32'h0);

    pin_in = 16'h8000;
    settle();
    check("R10 pin high, enable clear", {31'h0, irq_sh}, 32'h0);
    bus_wr(5'h10, 32'h0000_8000);
    check("R10 shared raised", {31'h0, irq_sh}, 32'h1);
    bus_rd(5'h10, 32'h0000_8000, "R5 ien readback");
    bus_wr(5'h10, 32'h0000_4000);
    check("R10 other enable only", {31'h0, irq_sh}, 32'h0);

    bus_wr(5'h10, 32'h0000_00FF);
    pin_in = 16'h0001;
    settle();
    check("R9 ien no effect on lower", {24'h0, irq_lo}, 32'h01);
    check("R10 lower enables no shared", {31'h0, irq_sh}, 32'h0);

    // clock gate freeze
    bus_wr(5'h10, 32'h0000_8000);
    pin_in = 16'h8005;
    settle();
    check("R10 shared before gate", {31'h0, irq_sh}, 32'h1);
    bus_wr(5'h14, 32'h0);
    check("R8 irqs low when gated", {23'h0, irq_sh, irq_lo}, 32'h0);
    pin_in = 16'h0000;
    settle();
    bus_rd(5'h0C, 32'h0000_8005, "R8 frozen capture");
    bus_wr(5'h14, 32'h1);
    check("R8 irqs return", {23'h0, irq_sh, irq_lo}, 32'h105);
    settle();
    bus_rd(5'h0C, 32'h0, "R4 capture resumes");

    bus_rd(5'h04, 32'h0, "R11 unmapped offset");

    // soft reset from programmed state
    pin_in = 16'h0003;
    settle();
    bus_wr(5'h14, 32'h2);
    @(negedge clk);
    check("R7 oe cleared", {16'h0, pin_oe}, 32'h0);
    check("R7 out cleared", {16'h0, pin_out}, 32'h0);
    bus_rd(5'h10, 32'h0, "R7 ien cleared");
    bus_rd(5'h0C, 32'h0, "R7 pin state cleared");
    bus_rd(5'h14, 32'h2, "R6 low-power reset readback");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11: %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule